// File: doc/BRIEF.md
# Reorder Buffer with Deferred Traps and Register Reclamation

This block is the in-order retirement queue of an out-of-order core that renames into a single shared physical register file. Each instruction gets one entry at decode. The decoder supplies the architectural destination, the freshly allocated physical register and the physical register that the same architectural register mapped to just before. The block returns the index of that entry, which travels with the instruction to execution.

Execution units report completion out of order by index. A report carries a fault flag and a cause code, and these are stored in the entry. Nothing is taken at that point. The oldest entry sits at the head. When it is complete and clean, it retires: the new mapping is reported so the committed map can be updated, and the previous mapping goes back to the free list, because no younger instruction can still read it. When the head is complete but faulted, the block raises a trap carrying the entry index and cause. It then discards every entry in flight and does not free the faulting instruction's old register.

Top module: `rob_reclaim`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready` is 1, and `retire_valid`, `free_valid` and `trap_valid` are 0.
- R2: A request with `alloc_valid` and `alloc_ready` both high is accepted at the clock edge. It stores the architectural destination, the new physical register and the old physical register in the entry numbered `alloc_idx`.
- R3: `alloc_ready` is 0 while DEPTH entries are held, and also in any cycle where `trap_valid` is 1. A request made while `alloc_ready` is 0 is ignored and creates no entry.
- R4: Completions may arrive in any order. An entry retires only when it is the oldest held entry and has been completed. At most one entry retires per cycle.
- R5: In the cycle after the head entry completes without a fault, `retire_valid` and `free_valid` are 1. In that cycle `retire_arch` and `retire_phys` show its destination and new physical register, and `free_phys` shows its old physical register. The entry leaves at that clock edge.
- R6: A fault reported at completion (`cmpl_fault`=1) raises nothing until its entry is the head. In that cycle `trap_valid` is 1, `trap_idx` is the entry index and `trap_cause` is the stored cause. All older entries retire before it.
- R7: In a trap cycle `free_valid` and `retire_valid` are 0. At the edge that ends the trap cycle, all entries are discarded and the buffer becomes empty. Later completions naming discarded entries have no effect.
- R8: A completion whose index does not name a held entry is ignored. A slot allocated later starts as not completed.
- R9: `alloc_idx` increases by one for each accepted request and wraps modulo DEPTH. After a trap it continues from where the allocation pointer stood; it does not return to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Decode requests an entry |
| alloc_arch | input | ARCH_W | Architectural destination |
| alloc_new_phys | input | PHYS_W | Newly allocated physical register |
| alloc_old_phys | input | PHYS_W | Previous mapping of the destination |
| alloc_ready | output | 1 | Entry can be accepted this cycle |
| alloc_idx | output | $clog2(DEPTH) | Index given to the request |
| cmpl_valid | input | 1 | Completion report |
| cmpl_idx | input | $clog2(DEPTH) | Entry being completed |
| cmpl_fault | input | 1 | Instruction faulted |
| cmpl_cause | input | CAUSE_W | Fault cause code |
| retire_valid | output | 1 | Head retires this cycle |
| retire_arch | output | ARCH_W | Destination of retiring entry |
| retire_phys | output | PHYS_W | New physical register of retiring entry |
| free_valid | output | 1 | Physical register returned to free list |
| free_phys | output | PHYS_W | Old physical register being freed |
| trap_valid | output | 1 | Faulting head taken; buffer flushes |
| trap_idx | output | $clog2(DEPTH) | Index of faulting entry |
| trap_cause | output | CAUSE_W | Cause of the fault |

## Verification
`alloc_ready` and `alloc_idx` follow the entries and pointers that the previous edge left, so they are due in the same cycle. A completion recorded at an edge shows on the retire, free or trap outputs in the following cycle, and only once its entry is the head. A trap empties the buffer by the next cycle. The bench drives inputs on the falling edge and compares every output just after, against a model it updates per edge from the requirements. Each output is therefore judged in exactly the cycle in which it is due. A sweep over every completion order of a full four-entry buffer, every fault position and a streaming phase with overlapping allocate, complete and retire covers the ordering cases.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    HEAD_WAIT   = 2'd0,
    HEAD_RETIRE = 2'd1,
    HEAD_TRAP   = 2'd2
  } head_act_t;
endpackage

// File: rtl/rob_ptr.sv
module rob_ptr #(
  parameter int IDX_W = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           inc,
  input  logic           load,
  input  logic [IDX_W:0] load_val,
  output logic [IDX_W:0] ptr
);
  logic [IDX_W:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (load)     ptr_d = load_val;
    else if (inc) ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/rob_slots.sv
module rob_slots #(
  parameter int DEPTH   = 8,
  parameter int IDX_W   = 3,
  parameter int ARCH_W  = 5,
  parameter int PHYS_W  = 6,
  parameter int CAUSE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [ARCH_W-1:0]  wr_arch,
  input  logic [PHYS_W-1:0]  wr_new,
  input  logic [PHYS_W-1:0]  wr_old,
  input  logic               done_en,
  input  logic [IDX_W-1:0]   done_idx,
  input  logic               done_fault,
  input  logic [CAUSE_W-1:0] done_cause,
  input  logic               pop_en,
  input  logic               wipe,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic               rd_live,
  output logic               rd_done,
  output logic               rd_fault,
  output logic [ARCH_W-1:0]  rd_arch,
  output logic [PHYS_W-1:0]  rd_new,
  output logic [PHYS_W-1:0]  rd_old,
  output logic [CAUSE_W-1:0] rd_cause,
  output logic [DEPTH-1:0]   live_vec
);
  logic [DEPTH-1:0]   done_vec;
  logic [DEPTH-1:0]   fault_vec;
  logic [ARCH_W-1:0]  arch_a  [DEPTH];
  logic [PHYS_W-1:0]  new_a   [DEPTH];
  logic [PHYS_W-1:0]  old_a   [DEPTH];
  logic [CAUSE_W-1:0] cause_a [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic live_q, live_d, dn_q, dn_d, flt_q, flt_d;
    logic hit_wr, hit_done, hit_pop;
    logic [ARCH_W-1:0]  arch_q;
    logic [PHYS_W-1:0]  new_q, old_q;
    logic [CAUSE_W-1:0] cause_q;

    assign hit_wr   = wr_en   && (wr_idx   == IDX_W'(i));
    assign hit_done = done_en && (done_idx == IDX_W'(i));
    assign hit_pop  = pop_en  && (rd_idx   == IDX_W'(i));

    always_comb begin
      live_d = live_q;
      dn_d   = dn_q;
      flt_d  = flt_q;
      if (hit_done) begin
        dn_d  = 1'b1;
        flt_d = done_fault;
      end
      if (hit_pop) begin
        live_d = 1'b0;
        dn_d   = 1'b0;
        flt_d  = 1'b0;
      end
      if (hit_wr) begin
        live_d = 1'b1;
        dn_d   = 1'b0;
        flt_d  = 1'b0;
      end
      if (wipe) begin
        live_d = 1'b0;
        dn_d   = 1'b0;
        flt_d  = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        live_q <= 1'b0;
        dn_q   <= 1'b0;
        flt_q  <= 1'b0;
      end else begin
        live_q <= live_d;
        dn_q   <= dn_d;
        flt_q  <= flt_d;
      end
    end

    always_ff @(posedge clk) begin
      if (hit_wr) begin
        arch_q <= wr_arch;
        new_q  <= wr_new;
        old_q  <= wr_old;
      end
      if (hit_done) cause_q <= done_cause;
    end

    assign live_vec[i]  = live_q;
    assign done_vec[i]  = dn_q;
    assign fault_vec[i] = flt_q;
    assign arch_a[i]    = arch_q;
    assign new_a[i]     = new_q;
    assign old_a[i]     = old_q;
    assign cause_a[i]   = cause_q;
  end

  assign rd_live  = live_vec[rd_idx];
  assign rd_done  = done_vec[rd_idx];
  assign rd_fault = fault_vec[rd_idx];
  assign rd_arch  = arch_a[rd_idx];
  assign rd_new   = new_a[rd_idx];
  assign rd_old   = old_a[rd_idx];
  assign rd_cause = cause_a[rd_idx];

  // R4: completion state exists only on held entries
  assert_done_only_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((done_vec | fault_vec) & ~live_vec) == '0);
endmodule

// File: rtl/rob_head_ctl.sv
module rob_head_ctl
  import rob_pkg::*;
(
  input  logic      head_live,
  input  logic      head_done,
  input  logic      head_fault,
  output head_act_t act
);
  always_comb begin
    act = HEAD_WAIT;
    if (head_live && head_done) act = head_fault ? HEAD_TRAP : HEAD_RETIRE;
  end
endmodule

// File: rtl/rob_reclaim.sv
module rob_reclaim
  import rob_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int ARCH_W  = 5,
  parameter int PHYS_W  = 6,
  parameter int CAUSE_W = 4,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_valid,
  input  logic [ARCH_W-1:0]  alloc_arch,
  input  logic [PHYS_W-1:0]  alloc_new_phys,
  input  logic [PHYS_W-1:0]  alloc_old_phys,
  output logic               alloc_ready,
  output logic [IDX_W-1:0]   alloc_idx,
  input  logic               cmpl_valid,
  input  logic [IDX_W-1:0]   cmpl_idx,
  input  logic               cmpl_fault,
  input  logic [CAUSE_W-1:0] cmpl_cause,
  output logic               retire_valid,
  output logic [ARCH_W-1:0]  retire_arch,
  output logic [PHYS_W-1:0]  retire_phys,
  output logic               free_valid,
  output logic [PHYS_W-1:0]  free_phys,
  output logic               trap_valid,
  output logic [IDX_W-1:0]   trap_idx,
  output logic [CAUSE_W-1:0] trap_cause
);
  logic [IDX_W:0]     head, tail, occ;
  logic [IDX_W-1:0]   head_idx;
  logic               full, alloc_fire, cmpl_fire;
  logic               h_live, h_done, h_fault;
  logic [ARCH_W-1:0]  h_arch;
  logic [PHYS_W-1:0]  h_new, h_old;
  logic [CAUSE_W-1:0] h_cause;
  logic [DEPTH-1:0]   live_vec;
  head_act_t          act;
  logic               do_retire, do_trap;

  assign head_idx   = head[IDX_W-1:0];
  assign occ        = tail - head;
  assign full       = (head_idx == tail[IDX_W-1:0]) && (head[IDX_W] != tail[IDX_W]);
  assign do_retire  = (act == HEAD_RETIRE);
  assign do_trap    = (act == HEAD_TRAP);
  assign alloc_fire = alloc_valid && alloc_ready;
  assign cmpl_fire  = cmpl_valid && live_vec[cmpl_idx] && !do_trap;

  rob_ptr #(.IDX_W(IDX_W)) u_head (
    .clk(clk), .rst_n(rst_n), .inc(do_retire), .load(do_trap),
    .load_val(tail), .ptr(head));

  rob_ptr #(.IDX_W(IDX_W)) u_tail (
    .clk(clk), .rst_n(rst_n), .inc(alloc_fire), .load(1'b0),
    .load_val(tail), .ptr(tail));

  rob_slots #(.DEPTH(DEPTH), .IDX_W(IDX_W), .ARCH_W(ARCH_W),
              .PHYS_W(PHYS_W), .CAUSE_W(CAUSE_W)) u_slots (
    .clk(clk), .rst_n(rst_n),
    .wr_en(alloc_fire), .wr_idx(tail[IDX_W-1:0]), .wr_arch(alloc_arch),
    .wr_new(alloc_new_phys), .wr_old(alloc_old_phys),
    .done_en(cmpl_fire), .done_idx(cmpl_idx), .done_fault(cmpl_fault),
    .done_cause(cmpl_cause), .pop_en(do_retire), .wipe(do_trap),
    .rd_idx(head_idx), .rd_live(h_live), .rd_done(h_done), .rd_fault(h_fault),
    .rd_arch(h_arch), .rd_new(h_new), .rd_old(h_old), .rd_cause(h_cause),
    .live_vec(live_vec));

  rob_head_ctl u_ctl (
    .head_live(h_live), .head_done(h_done), .head_fault(h_fault), .act(act));

  assign alloc_ready  = !full && !do_trap;
  assign alloc_idx    = tail[IDX_W-1:0];
  assign retire_valid = do_retire;
  assign retire_arch  = h_arch;
  assign retire_phys  = h_new;
  assign free_valid   = do_retire;
  assign free_phys    = h_old;
  assign trap_valid   = do_trap;
  assign trap_idx     = head_idx;
  assign trap_cause   = h_cause;

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= (IDX_W+1)'(DEPTH));

  assert_alloc_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> live_vec[$past(tail[IDX_W-1:0])]);

  assert_head_steps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid |=> (head == $past(head) + 1'b1));

  assert_one_outcome_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({retire_valid, trap_valid}));

  assert_trap_no_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> !free_valid);

  assert_trap_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> ((head == tail) && (live_vec == '0)));
endmodule

// File: tb/sim_rob_reclaim.sv
`timescale 1ns/1ps
module sim_rob_reclaim;
  localparam int D = 4;
  localparam int AW = 3, PW = 5, CW = 3, IW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic av = 1'b0, cv = 1'b0, cf = 1'b0;
  logic [AW-1:0] aa = '0;
  logic [PW-1:0] an = '0, ao = '0;
  logic [IW-1:0] ci = '0;
  logic [CW-1:0] cc = '0;
  logic ready, rv, fv, tv;
  logic [IW-1:0] aidx, tidx;
  logic [AW-1:0] rarch;
  logic [PW-1:0] rphys, fphys;
  logic [CW-1:0] tcause;

  always #2.5 clk = ~clk;

  rob_reclaim #(.DEPTH(D), .ARCH_W(AW), .PHYS_W(PW), .CAUSE_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .alloc_valid(av), .alloc_arch(aa),
    .alloc_new_phys(an), .alloc_old_phys(ao), .alloc_ready(ready),
    .alloc_idx(aidx), .cmpl_valid(cv), .cmpl_idx(ci), .cmpl_fault(cf),
    .cmpl_cause(cc), .retire_valid(rv), .retire_arch(rarch),
    .retire_phys(rphys), .free_valid(fv), .free_phys(fphys),
    .trap_valid(tv), .trap_idx(tidx), .trap_cause(tcause));

  int total = 0, bad = 0;
  bit m_live[D], m_done[D], m_flt[D];
  int m_arch[D], m_new[D], m_old[D], m_cause[D];
  int m_head = 0, m_tail = 0, m_cnt = 0;

  task automatic chk(input string ctx, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", ctx, what, act, exp);
    end
  endtask

  task automatic step(input string ctx, input bit a_v, input int a_a, input int a_n,
                      input int a_o, input bit c_v, input int c_i, input bit c_f,
                      input int c_c);
    int h;
    bit tr, rt, rd;
    @(negedge clk);
    av = a_v; aa = AW'(a_a); an = PW'(a_n); ao = PW'(a_o);
    cv = c_v; ci = IW'(c_i); cf = c_f; cc = CW'(c_c);
    #1;
    h  = m_head % D;
    tr = m_live[h] && m_done[h] && m_flt[h];
    rt = m_live[h] && m_done[h] && !m_flt[h];
    rd = (m_cnt < D) && !tr;
    chk(ctx, "R3 alloc_ready", int'(ready), int'(rd));
    chk(ctx, "R9 alloc_idx", int'(aidx), m_tail % D);
    chk(ctx, "R4 retire_valid", int'(rv), int'(rt));
    chk(ctx, "R5 free_valid", int'(fv), int'(rt));
    chk(ctx, "R6 trap_valid", int'(tv), int'(tr));
    if (rt) begin
      chk(ctx, "R5 retire_arch", int'(rarch), m_arch[h]);
      chk(ctx, "R5 retire_phys", int'(rphys), m_new[h]);
      chk(ctx, "R5 free_phys", int'(fphys), m_old[h]);
    end
    if (tr) begin
      chk(ctx, "R6 trap_idx", int'(tidx), h);
      chk(ctx, "R6 trap_cause", int'(tcause), m_cause[h]);
    end
    if (tr) begin
      for (int k = 0; k < D; k++) begin m_live[k] = 0; m_done[k] = 0; m_flt[k] = 0; end
      m_head = m_tail; m_cnt = 0;
    end else begin
      if (c_v && m_live[c_i]) begin
        m_done[c_i] = 1; m_flt[c_i] = c_f; m_cause[c_i] = c_c % (1 << CW);
      end
      if (rt) begin
        m_live[h] = 0; m_done[h] = 0; m_flt[h] = 0; m_head++; m_cnt--;
      end
      if (a_v && rd) begin
        m_live[m_tail % D] = 1; m_done[m_tail % D] = 0; m_flt[m_tail % D] = 0;
        m_arch[m_tail % D] = a_a % (1 << AW);
        m_new[m_tail % D]  = a_n % (1 << PW);
        m_old[m_tail % D]  = a_o % (1 << PW);
        m_tail++; m_cnt++;
      end
    end
    @(posedge clk);
  endtask

  task automatic idle(input string ctx, input int n);
    for (int k = 0; k < n; k++) step(ctx, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base;
    int ord[D];
    int pool[D];
    for (int k = 0; k < D; k++) begin m_live[k] = 0; m_done[k] = 0; m_flt[k] = 0; end
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset", "alloc_ready", int'(ready), 1);
    chk("R1 reset", "retire_valid", int'(rv), 0);
    chk("R1 reset", "free_valid", int'(fv), 0);
    chk("R1 reset", "trap_valid", int'(tv), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk);

    // R8: completion to an empty buffer, then allocate that slot
    step("R8 stray", 0, 0, 0, 0, 1, 0, 0, 0);
    step("R8 alloc", 1, 3, 9, 4, 0, 0, 0, 0);
    idle("R8 not-done", 2);
    step("R8 complete", 0, 0, 0, 0, 1, 0, 0, 0);
    idle("R8 drain", 2);

    // R4/R5: every completion order of a full buffer; 5th request hits R3 full
    for (int p = 0; p < 24; p++) begin
      int r;
      base = m_tail;
      for (int k = 0; k <= D; k++)
        step("R3 fill", 1, p + k, (p * 3 + k) % 32, (p * 5 + k + 7) % 32, 0, 0, 0, 0);
      for (int k = 0; k < D; k++) pool[k] = k;
      r = p;
      for (int k = 0; k < D; k++) begin
        int f, sel;
        f = 1;
        for (int j = 1; j < D - k; j++) f = f * j;
        sel = r / f; r = r % f;
        ord[k] = pool[sel];
        for (int j = sel; j < D - 1 - k; j++) pool[j] = pool[j + 1];
      end
      for (int k = 0; k < D; k++)
        step("R4 order", 0, 0, 0, 0, 1, (base + ord[k]) % D, 0, 0);
      idle("R5 drain", D + 1);
    end

    // R6/R7: fault at each position, late completion to a discarded slot, refill
    for (int e = 0; e < D; e++) begin
      base = m_tail;
      for (int k = 0; k < D; k++)
        step("R6 fill", 1, e + k, (e * 7 + k) % 32, (e + 2 * k) % 32, 0, 0, 0, 0);
      for (int k = D - 1; k >= 0; k--)
        step("R6 complete", 0, 0, 0, 0, 1, (base + k) % D, k == e, e + 1);
      idle("R7 trap", D + 1);
      step("R7 discarded", 0, 0, 0, 0, 1, (base + D - 1) % D, 0, 0);
      idle("R7 after", 1);
      step("R7 refill", 1, 5, 17, 18, 0, 0, 0, 0);
      step("R9 refill", 1, 6, 19, 20, 1, m_tail % D ? (m_tail - 1) % D : D - 1, 0, 0);
      step("R7 refill", 0, 0, 0, 0, 1, (m_tail - 1) % D, 0, 0);
      idle("R7 refill", 3);
    end

    // R2/R9: streaming allocate, complete two behind, retire in same cycles
    for (int n = 0; n < 40; n++) begin
      if (n >= 2) step("R2 stream", 1, n, n % 32, (n + 11) % 32, 1, (m_tail - 2) % D, 0, 0);
      else        step("R2 stream", 1, n, n % 32, (n + 11) % 32, 0, 0, 0, 0);
    end
    step("R9 tail", 0, 0, 0, 0, 1, (m_tail - 2) % D, 0, 0);
    step("R9 tail", 0, 0, 0, 0, 1, (m_tail - 1) % D, 0, 0);
    idle("R9 drain", D + 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule